// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupts

This block is a memory-mapped controller for 32 general-purpose pins, organised as four identical sections of eight pins. Each section has its own 64-byte register window. That window holds the pin direction, the driven output value and the synchronised input value. It also holds raw and masked interrupt status, separate strobe addresses for setting and clearing interrupt mask bits, and a per-pin choice between level and edge interrupt detection.

A host reaches the registers over a simple synchronous bus. A write takes effect on the clock edge where the write enable is high. A read strobe returns data and a valid flag one cycle later. On the pin side the block drives an output vector and an output-enable vector, and it samples an input vector through a two-flop synchroniser. A single interrupt line is high whenever any unmasked status bit in any section is set.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is all 0, every mask bit is 1, all status bits are 0, every pin is in edge mode and irq is 0.
- R2: Address bits [7:6] select the section and bits [5:0] select the register. Pin n is bit n&7 of section n>>3, so pin 10 is bit 2 of the window at 0x40.
- R3: The direction register sits at offset 0x10, where 1 means input and 0 means output. pin_oe is the inverse of the direction bit. The register at offset 0x14 drives pin_out and reads back.
- R4: Offset 0x18 reads the pin inputs after a two-flop synchroniser. A read captured on the first or second clock edge after a pin changes still shows the old value.
- R5: In edge mode, a rising edge of the synchronised input sets the raw status bit, readable at offset 0x04. The bit stays set until software writes 1 to it at offset 0x04. An input held high does not set the bit again.
- R6: Writing 1 to a bit at offset 0x20 selects level mode for that pin, and the register reads back the selection. In level mode the raw status bit is set on every cycle the synchronised input is high, so a clear has no lasting effect while the input stays high.
- R7: Offset 0x08 reads the mask. Writing 1s there sets those mask bits. Writing 1s to offset 0x0C clears those mask bits. Offset 0x0C reads as 0.
- R8: Offset 0x00 reads raw status AND NOT mask. irq is the OR of the masked status of all four sections.
- R9: When a status bit is set and cleared on the same edge, the set wins and the bit stays 1.
- R10: bus_rvalid rises exactly one cycle after a bus_rd strobe. bus_rdata bits [31:8] are always 0. Unused offsets (for example 0x1C) read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address: section in [7:6], register in [5:0] |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data (bits [7:0] used) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_rd |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can act on the same status bit in the same cycle: hardware detection of an edge, and a software write-1-to-clear. The bench provokes this by raising a pin and then timing the clear write so that it is sampled on the same edge that the synchronised edge reaches the status register. That edge is the third edge after the pin change. The bench then judges the result by reading the raw status, which must still be 1, and by checking that irq stays high while the bit is unmasked. A second clear with no edge must then bring the bit to 0. Level mode gets the same treatment: the bench clears a status bit while its input is held high and requires the bit to read back as set.

// File: rtl/gpio_sect_pkg.sv
package gpio_sect_pkg;
    localparam int NUM_SECT  = 4;
    localparam int SECT_PINS = 8;
    localparam int DATA_W    = 32;
    localparam int WIN_AW    = 6;
    localparam int SECT_AW   = $clog2(NUM_SECT);
    localparam int ADDR_W    = SECT_AW + WIN_AW;
    localparam int NUM_PINS  = NUM_SECT * SECT_PINS;

    // register offsets inside a section window
    localparam logic [WIN_AW-1:0] OFF_MSTAT  = 6'h00;
    localparam logic [WIN_AW-1:0] OFF_RAW    = 6'h04;
    localparam logic [WIN_AW-1:0] OFF_MSKSET = 6'h08;
    localparam logic [WIN_AW-1:0] OFF_MSKCLR = 6'h0C;
    localparam logic [WIN_AW-1:0] OFF_DIR    = 6'h10;
    localparam logic [WIN_AW-1:0] OFF_OUT    = 6'h14;
    localparam logic [WIN_AW-1:0] OFF_IN     = 6'h18;
    localparam logic [WIN_AW-1:0] OFF_LVL    = 6'h20;

    typedef logic [SECT_PINS-1:0] lane_t;

    typedef struct packed {
        lane_t dir;
        lane_t dout;
        lane_t mask;
        lane_t stat;
        lane_t lvl;
    } sect_regs_t;

    localparam sect_regs_t SECT_RESET = '{
        dir:  '1,
        dout: '0,
        mask: '1,
        stat: '0,
        lvl:  '0
    };

    function automatic logic [SECT_AW-1:0] sect_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WIN_AW];
    endfunction

    function automatic logic [WIN_AW-1:0] off_of(input logic [ADDR_W-1:0] a);
        return a[WIN_AW-1:0];
    endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_sect_bank.sv
module gpio_sect_bank
    import gpio_sect_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              we,
    input  logic [WIN_AW-1:0] off,
    input  lane_t             wdata,
    input  lane_t             syn,
    output lane_t             rbyte,
    output lane_t             dout,
    output lane_t             oe,
    output lane_t             mstat
);
    sect_regs_t r;
    lane_t      prev;
    lane_t      set_v;
    lane_t      clr_v;
    logic       wr;

    assign wr    = hit && we;
    assign set_v = (r.lvl & syn) | (~r.lvl & syn & ~prev);
    assign clr_v = (wr && off == OFF_RAW) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            r    <= SECT_RESET;
            prev <= '0;
        end else begin
            prev   <= syn;
            r.stat <= (r.stat & ~clr_v) | set_v;
            if (wr) begin
                case (off)
                    OFF_MSKSET: r.mask <= r.mask | wdata;
                    OFF_MSKCLR: r.mask <= r.mask & ~wdata;
                    OFF_DIR:    r.dir  <= wdata;
                    OFF_OUT:    r.dout <= wdata;
                    OFF_LVL:    r.lvl  <= wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        case (off)
            OFF_MSTAT:  rbyte = r.stat & ~r.mask;
            OFF_RAW:    rbyte = r.stat;
            OFF_MSKSET: rbyte = r.mask;
            OFF_DIR:    rbyte = r.dir;
            OFF_OUT:    rbyte = r.dout;
            OFF_IN:     rbyte = syn;
            OFF_LVL:    rbyte = r.lvl;
            default:    rbyte = '0;
        endcase
    end

    assign dout  = r.dout;
    assign oe    = ~r.dir;
    assign mstat = r.stat & ~r.mask;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((r.stat & $past(set_v)) == $past(set_v))); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clr_v == '0) |=> ((r.stat & $past(r.stat)) == $past(r.stat))); // R5
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (|(clr_v & ~set_v)) |=> ((r.stat & $past(clr_v & ~set_v)) == '0)); // R5
    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (wr && off == OFF_MSKSET) |=> ((r.mask & $past(wdata)) == $past(wdata))); // R7
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr && off == OFF_MSKCLR) |=> ((r.mask & $past(wdata)) == '0)); // R7
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
    import gpio_sect_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    logic [NUM_PINS-1:0]           pin_syn;
    lane_t [NUM_SECT-1:0]          rbytes;
    lane_t [NUM_SECT-1:0]          mstats;
    logic  [SECT_AW-1:0]           sect;
    logic  [WIN_AW-1:0]            off;
    logic                          unused_wdata_hi;

    assign sect            = sect_of(bus_addr);
    assign off             = off_of(bus_addr);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SECT_PINS];

    gpio_sync2 #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_syn)
    );

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        gpio_sect_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .hit   (sect == SECT_AW'(s)),
            .we    (bus_we),
            .off   (off),
            .wdata (bus_wdata[SECT_PINS-1:0]),
            .syn   (pin_syn[s*SECT_PINS +: SECT_PINS]),
            .rbyte (rbytes[s]),
            .dout  (pin_out[s*SECT_PINS +: SECT_PINS]),
            .oe    (pin_oe[s*SECT_PINS +: SECT_PINS]),
            .mstat (mstats[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? {{(DATA_W-SECT_PINS){1'b0}}, rbytes[sect]} : '0;
        end
    end

    assign irq = |mstats;

    AST_RDATA_NARROW: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:SECT_PINS] == '0); // R10
    AST_RVALID_TIMING: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid); // R10
endmodule

// File: tb/gpio_sect_ctrl_test.sv
module gpio_sect_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_sect_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(8'h08, d);
        check("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
        check("R1 mask", d, 32'hFF);
        bus_read(8'hC4, d); check("R1 status", d, 32'h0);
        bus_read(8'h60, d); check("R1 level sel", d, 32'h0);
        bus_read(8'h90, d); check("R1 dir", d, 32'hFF);
        @(negedge clk);
        check("R10 rvalid drop", {31'b0, bus_rvalid}, 32'h0);
    endtask

    task automatic t_dir_out;
        logic [31:0] d;
        bus_write(8'h10, 32'hFFFF_FF0F);
        check("R3 oe sec0", pin_oe, 32'h0000_00F0);
        bus_write(8'h14, 32'hA5);
        check("R3 out sec0", pin_out, 32'h0000_00A5);
        bus_write(8'hD0, 32'h00);
        check("R2 oe sec3", pin_oe, 32'hFF00_00F0);
        bus_read(8'h10, d); check("R3 dir readback", d, 32'h0F);
        bus_write(8'h1C, 32'hFF);
        check("R10 unused write out", pin_out, 32'h0000_00A5);
        check("R10 unused write oe", pin_oe, 32'hFF00_00F0);
        bus_read(8'h1C, d); check("R10 unused read", d, 32'h0);
        bus_read(8'h14, d); check("R3 out readback", d, 32'hA5);
    endtask

    task automatic t_sync;
        logic [31:0] d;
        pin_in[24] = 1'b1;
        bus_read(8'hD8, d); check("R4 sync delay", d, 32'h0);
        repeat (2) @(negedge clk);
        bus_read(8'hD8, d); check("R4 input", d, 32'h01);
    endtask

    task automatic t_edge_mask;
        logic [31:0] d;
        pin_in[10] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(8'h44, d); check("R5 edge raw pin10", d, 32'h04);
        bus_read(8'h58, d); check("R2 input pin10", d, 32'h04);
        bus_read(8'h40, d); check("R8 masked zero", d, 32'h0);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        bus_write(8'h4C, 32'h04);
        bus_read(8'h40, d); check("R8 masked", d, 32'h04);
        check("R8 irq", {31'b0, irq}, 32'h1);
        bus_read(8'h4C, d); check("R7 unmask reads 0", d, 32'h0);
        bus_read(8'h48, d); check("R7 mask after clear", d, 32'hFB);
        bus_write(8'h48, 32'h04);
        check("R7 irq after mask", {31'b0, irq}, 32'h0);
        bus_read(8'h48, d); check("R7 mask set", d, 32'hFF);
        bus_write(8'h44, 32'h04);
        repeat (3) @(negedge clk);
        bus_read(8'h44, d); check("R5 cleared while high", d, 32'h0);
        pin_in[10] = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(8'h44, d); check("R5 fall no status", d, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        bus_write(8'hA0, 32'h02);
        bus_read(8'hA0, d); check("R6 level readback", d, 32'h02);
        pin_in[17] = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(8'h84, d); check("R6 level set", d, 32'h02);
        bus_write(8'h84, 32'h02);
        bus_read(8'h84, d); check("R6 clear while high", d, 32'h02);
        pin_in[17] = 1'b0;
        repeat (3) @(negedge clk);
        bus_write(8'h84, 32'h02);
        bus_read(8'h84, d); check("R6 clear after low", d, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        bus_write(8'h0C, 32'h01);
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h01; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bus_read(8'h04, d); check("R9 set wins", d, 32'h01);
        check("R9 irq", {31'b0, irq}, 32'h1);
        bus_write(8'h04, 32'h01);
        bus_read(8'h04, d); check("R5 plain clear", d, 32'h0);
        check("R8 irq clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_dir_out;
        t_sync;
        t_edge_mask;
        t_level;
        t_set_wins;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule